// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between a clock generator and its output pins. It gates a set of differential processor clock pairs and a set of single-ended bus clocks in response to two active-low stop requests, one per clock group. The source clocks come in as ordinary logic levels and are sampled by a faster system clock. Every output is a register that follows its source clock, so an output can only change in response to a detected source edge. It never cuts a pulse short.

When the processor stop request drops, it is sampled on two successive source rising edges. After that, each pair marked stoppable finishes its current cycle and then parks with the true leg high and the complement leg low. Pairs not marked stoppable keep running. When the bus stop request drops, it is sampled on a source rising edge. The plain bus outputs, and the free-running outputs that are marked stoppable, then freeze low at the next source falling edge. On release, each parked output restarts with a full-width first phase.

Top module: `clkstop_top`

## Requirements
- R1: While `rst` is high, every `cpu_t` bit is 0, every `cpu_c` bit is 1 and every bus output is 0. After reset all sampling and parking state is cleared, so every output toggles again even if a stop request is still held low.
- R2: Each `cpu_c[i]` is always the inverse of `cpu_t[i]`.
- R3: A processor stop asserted between source rising edges is seen on the next two rising edges. A stoppable true output makes its last rise on the third source rising edge after the stop is asserted, which gives exactly three output rises.
- R4: A parked pair holds `cpu_t[i]`=1 and `cpu_c[i]`=0 for as long as the stop stays asserted.
- R5: A pair whose bit in `cpu_stoppable` is 0 (bit i controls pair i; 1 means the pair obeys the stop) keeps toggling at the source rate while the processor stop is asserted.
- R6: After the processor stop is released, a parked true output stays high through two further source rising edges. It falls at the source falling edge that follows the second of those edges.
- R7: The bus stop is sampled on a source rising edge. Every `pci_out` bit then falls at the next source falling edge and stays low while the stop is held.
- R8: A `pcif_out[j]` with `pcif_stoppable[j]`=1 behaves like `pci_out`. One with the bit at 0 follows the bus source clock at all times.
- R9: After the bus stop is released, every parked bus output rises on the first source rising edge that samples the release.
- R10: No output produces a high or low phase shorter than half of its source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_src | input | 1 | Processor source clock, as a logic level |
| pci_src | input | 1 | Bus source clock, as a logic level |
| cpu_stop_n | input | 1 | Active-low processor stop request |
| pci_stop_n | input | 1 | Active-low bus stop request |
| cpu_stoppable | input | NCPU | Per-pair stop enable, 1 = obeys stop |
| pcif_stoppable | input | NPCIF | Per free-running output stop enable, 1 = obeys stop |
| cpu_t | output | NCPU | True legs of the processor pairs |
| cpu_c | output | NCPU | Complement legs of the processor pairs |
| pci_out | output | NPCI | Plain bus clock outputs, always stoppable |
| pcif_out | output | NPCIF | Free-running bus clock outputs |

## Verification
The properties assume three things about the inputs:
- Both source clocks are at least several system cycles per phase.
- The stoppable masks are static outside reset.
- Reset is held for at least two cycles.

The stimulus derives both sources from counters on the system clock, with phases of 8 and 20 cycles. It sets the masks before reset and never touches them afterwards. Stop requests are driven at a random phase, kept a few cycles clear of the next source rising edge so that the sampling edge is known. Each directed task then counts source and output edges against the edge-by-edge expectations in the requirements.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/clkstop_edge.sv
module clkstop_edge
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl,
  output edge_t ev
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_comb begin
    ev.rise = lvl & ~prev;
    ev.fall = ~lvl & prev;
  end
endmodule

// File: rtl/clkstop_cpu_lane.sv
module clkstop_cpu_lane
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  edge_t ev,
  input  logic  halt,
  output logic  t,
  output logic  c
);
  logic parked;

  always_ff @(posedge clk) begin
    if (rst) begin
      t      <= 1'b0;
      c      <= 1'b1;
      parked <= 1'b0;
    end else if (ev.rise) begin
      t      <= 1'b1;
      c      <= 1'b0;
      parked <= halt;
    end else if (ev.fall && !(parked && halt)) begin
      t      <= 1'b0;
      c      <= 1'b1;
      parked <= 1'b0;
    end
  end
endmodule

// File: rtl/clkstop_pci_lane.sv
module clkstop_pci_lane
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  edge_t ev,
  input  logic  stoppable,
  input  logic  req_now,
  input  logic  req_held,
  output logic  out
);
  logic parked;

  always_ff @(posedge clk) begin
    if (rst) begin
      out    <= 1'b0;
      parked <= 1'b0;
    end else if (ev.rise) begin
      if (!(parked && stoppable && req_now)) begin
        out    <= 1'b1;
        parked <= 1'b0;
      end
    end else if (ev.fall) begin
      out    <= 1'b0;
      parked <= req_held && stoppable;
    end
  end
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NPCI = 7,
  parameter int NPCIF = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_src,
  input  logic             pci_src,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic [NCPU-1:0]  cpu_stoppable,
  input  logic [NPCIF-1:0] pcif_stoppable,
  output logic [NCPU-1:0]  cpu_t,
  output logic [NCPU-1:0]  cpu_c,
  output logic [NPCI-1:0]  pci_out,
  output logic [NPCIF-1:0] pcif_out
);
  localparam int NGRP = 2;
  localparam int CPU_SMP = 2;

  logic [NGRP-1:0] src_s, stop_s;
  edge_t cpu_ev, pci_ev;
  logic cpu_req, pci_req;
  logic [CPU_SMP-1:0] cpu_smp;
  logic pci_smp;
  logic cpu_rise, cpu_fall, pci_rise, pci_fall;

  clkstop_sync #(.W(NGRP), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_src_sync (
    .clk(clk), .rst(rst), .d({pci_src, cpu_src}), .q(src_s));

  clkstop_sync #(.W(NGRP), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_stop_sync (
    .clk(clk), .rst(rst), .d({pci_stop_n, cpu_stop_n}), .q(stop_s));

  clkstop_edge u_cpu_edge (.clk(clk), .rst(rst), .lvl(src_s[0]), .ev(cpu_ev));
  clkstop_edge u_pci_edge (.clk(clk), .rst(rst), .lvl(src_s[1]), .ev(pci_ev));

  assign cpu_req  = ~stop_s[0];
  assign pci_req  = ~stop_s[1];
  assign cpu_rise = cpu_ev.rise;
  assign cpu_fall = cpu_ev.fall;
  assign pci_rise = pci_ev.rise;
  assign pci_fall = pci_ev.fall;

  // processor request sampled on successive source rising edges
  always_ff @(posedge clk) begin
    if (rst) cpu_smp <= '0;
    else if (cpu_ev.rise) cpu_smp <= {cpu_smp[CPU_SMP-2:0], cpu_req};
  end

  // bus request sampled on a source rising edge
  always_ff @(posedge clk) begin
    if (rst) pci_smp <= 1'b0;
    else if (pci_ev.rise) pci_smp <= pci_req;
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    clkstop_cpu_lane u_lane (
      .clk(clk), .rst(rst), .ev(cpu_ev),
      .halt(cpu_smp[CPU_SMP-1] & cpu_stoppable[i]),
      .t(cpu_t[i]), .c(cpu_c[i]));
  end

  for (genvar j = 0; j < NPCI; j++) begin : g_pci
    clkstop_pci_lane u_lane (
      .clk(clk), .rst(rst), .ev(pci_ev), .stoppable(1'b1),
      .req_now(pci_req), .req_held(pci_smp), .out(pci_out[j]));
  end

  for (genvar j = 0; j < NPCIF; j++) begin : g_pcif
    clkstop_pci_lane u_lane (
      .clk(clk), .rst(rst), .ev(pci_ev), .stoppable(pcif_stoppable[j]),
      .req_now(pci_req), .req_held(pci_smp), .out(pcif_out[j]));
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int NCPU = 3,
  parameter int NPCI = 7,
  parameter int NPCIF = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NCPU-1:0]  cpu_t,
  input logic [NCPU-1:0]  cpu_c,
  input logic [NPCI-1:0]  pci_out,
  input logic [NPCIF-1:0] pcif_out,
  input logic [NCPU-1:0]  cpu_stoppable,
  input logic [NPCIF-1:0] pcif_stoppable,
  input logic             cpu_rise,
  input logic             cpu_fall,
  input logic             pci_rise,
  input logic             pci_fall
);
  // R2
  pair_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_c == ~cpu_t);

  // R3
  cpu_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((~cpu_t & $past(cpu_t)) != '0) |-> $past(cpu_fall));

  // R5
  cpu_free_run_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_fall) |-> ((cpu_t & ~cpu_stoppable) == '0));

  // R7
  pci_low_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pci_fall) |-> (pci_out == '0));

  // R8
  pcif_free_run_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pci_rise) |-> ((~pcif_out & ~pcif_stoppable) == '0));

  // R9
  pci_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((pci_out & ~$past(pci_out)) != '0) |-> $past(pci_rise));
endmodule

bind clkstop_top clkstop_chk #(.NCPU(NCPU), .NPCI(NPCI), .NPCIF(NPCIF)) u_chk (
  .clk(clk), .rst(rst), .cpu_t(cpu_t), .cpu_c(cpu_c), .pci_out(pci_out),
  .pcif_out(pcif_out), .cpu_stoppable(cpu_stoppable),
  .pcif_stoppable(pcif_stoppable), .cpu_rise(cpu_rise), .cpu_fall(cpu_fall),
  .pci_rise(pci_rise), .pci_fall(pci_fall));

// File: tb/sim_clkstop_top.sv
module sim_clkstop_top;
  localparam int NCPU = 3, NPCI = 7, NPCIF = 3;
  localparam int CPU_P = 16, PCI_P = 40;
  localparam int NALL = NCPU + NPCI + NPCIF;

  logic clk = 0, rst = 1;
  logic cpu_src = 0, pci_src = 0, cpu_stop_n = 1, pci_stop_n = 1;
  logic [NCPU-1:0]  cpu_stoppable = 3'b101;
  logic [NPCIF-1:0] pcif_stoppable = 3'b101;
  logic [NCPU-1:0]  cpu_t, cpu_c;
  logic [NPCI-1:0]  pci_out;
  logic [NPCIF-1:0] pcif_out;

  int checks = 0, errors = 0, runts = 0, inv_err = 0;
  int cpu_cnt = 0, pci_cnt = 0;
  bit mon_en = 0, done = 0;

  clkstop_top u0 (.*);

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    cpu_cnt = (cpu_cnt + 1) % CPU_P;
    pci_cnt = (pci_cnt + 1) % PCI_P;
    cpu_src = (cpu_cnt < CPU_P/2);
    pci_src = (pci_cnt < PCI_P/2);
  end

  // pulse width and complement monitor (R10, R2)
  logic [NALL-1:0] allv, prevv;
  int run [NALL];
  bit seen [NALL];
  assign allv = {pcif_out, pci_out, cpu_t};
  always @(negedge clk) begin
    if (!mon_en) begin
      for (int i = 0; i < NALL; i++) begin seen[i] = 0; run[i] = 0; end
    end else begin
      for (int i = 0; i < NALL; i++) begin
        if (allv[i] != prevv[i]) begin
          if (seen[i] && run[i] < ((i < NCPU) ? CPU_P/2 : PCI_P/2)) begin
            runts++;
            $display("FAIL R10 output %0d phase width actual=%0d expected>=%0d",
                     i, run[i], (i < NCPU) ? CPU_P/2 : PCI_P/2);
          end
          seen[i] = 1;
          run[i] = 1;
        end else run[i]++;
      end
      if (cpu_c !== ~cpu_t) begin
        inv_err++;
        $display("FAIL R2 complement actual=%0d expected=%0d", cpu_c, ~cpu_t);
      end
    end
    prevv = allv;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    mon_en = 0;
    rst = 1;
    repeat (2) tick();
    chk(cpu_t == '0, "R1", "cpu_t in reset", cpu_t, 0);
    chk(cpu_c == '1, "R1", "cpu_c in reset", cpu_c, 7);
    chk(pci_out == '0 && pcif_out == '0, "R1", "bus outputs in reset",
        {pcif_out, pci_out}, 0);
    tick();
    rst = 0;
    repeat (4) tick();
    mon_en = 1;
  endtask

  task automatic wait_cpu(int p);
    do tick(); while (cpu_cnt != p);
  endtask

  task automatic wait_pci(int p);
    do tick(); while (pci_cnt != p);
  endtask

  task automatic t_reset();
    int r0 = 0, rp = 0;
    logic a, b;
    do_reset();
    for (int k = 0; k < 100; k++) begin
      a = cpu_t[0]; b = pci_out[0]; tick();
      if (cpu_t[0] && !a) r0++;
      if (pci_out[0] && !b) rp++;
    end
    chk(r0 >= 5, "R1", "cpu_t[0] rises after reset", r0, 6);
    chk(rp >= 2, "R1", "pci_out[0] rises after reset", rp, 2);
  endtask

  task automatic t_cpu_stop();
    int p = int'($urandom_range(12, 5));
    int r0 = 0, r1 = 0, r2 = 0, bad = 0;
    logic a0, a1, a2;
    wait_cpu(p);
    cpu_stop_n = 0;
    for (int k = 0; k < 96; k++) begin
      a0 = cpu_t[0]; a1 = cpu_t[1]; a2 = cpu_t[2]; tick();
      if (cpu_t[0] && !a0) r0++;
      if (cpu_t[1] && !a1) r1++;
      if (cpu_t[2] && !a2) r2++;
    end
    // R3: two sampling edges then one more rise
    chk(r0 == 3, "R3", "pair0 rises after stop", r0, 3);
    chk(r2 == 3, "R3", "pair2 rises after stop", r2, 3);
    // R5: non-stoppable pair runs on
    chk(r1 == 6, "R5", "pair1 rises during stop", r1, 6);
    for (int k = 0; k < 32; k++) begin
      tick();
      if (!(cpu_t[0] && cpu_t[2] && !cpu_c[0] && !cpu_c[2])) bad++;
    end
    // R4: parked levels
    chk(bad == 0, "R4", "cycles off parked level", bad, 0);
  endtask

  task automatic t_cpu_release();
    int p = int'($urandom_range(12, 5));
    int n = 0;
    wait_cpu(p);
    cpu_stop_n = 1;
    for (int k = 0; k < 100; k++) begin
      tick();
      if (cpu_cnt == 0) n++;
      if (!cpu_t[0]) break;
    end
    chk(n == 2, "R6", "source rises before pair0 resumes", n, 2);
    repeat (40) tick();
  endtask

  task automatic t_pci_stop();
    int p = int'($urandom_range(35, 5));
    int r0 = 0, rf0 = 0, rf1 = 0, bad = 0, rfree = 0;
    logic a, b, c;
    wait_pci(p);
    pci_stop_n = 0;
    for (int k = 0; k < 120; k++) begin
      a = pci_out[0]; b = pcif_out[0]; c = pcif_out[1]; tick();
      if (pci_out[0] && !a) r0++;
      if (pcif_out[0] && !b) rf0++;
      if (pcif_out[1] && !c) rf1++;
    end
    chk(r0 == 1, "R7", "pci_out[0] rises after stop", r0, 1);
    chk(rf0 == 1, "R8", "stoppable pcif[0] rises after stop", rf0, 1);
    chk(rf1 == 3, "R8", "free pcif[1] rises during stop", rf1, 3);
    for (int k = 0; k < 80; k++) begin
      c = pcif_out[1]; tick();
      if (pci_out != '0 || (pcif_out & pcif_stoppable) != '0) bad++;
      if (pcif_out[1] && !c) rfree++;
    end
    chk(bad == 0, "R7", "cycles with a stopped bus output high", bad, 0);
    chk(rfree == 2, "R8", "free pcif[1] rises while held", rfree, 2);
  endtask

  task automatic t_pci_release();
    int p = int'($urandom_range(35, 5));
    int n = 0;
    wait_pci(p);
    pci_stop_n = 1;
    for (int k = 0; k < 100; k++) begin
      tick();
      if (pci_cnt == 0) n++;
      if (pci_out[0]) break;
    end
    chk(n == 1, "R9", "source rises before bus resumes", n, 1);
    chk(pci_out == '1 && pcif_out == '1, "R9", "bus outputs on resume",
        {pcif_out, pci_out}, (1 << NALL - NCPU) - 1);
    repeat (60) tick();
  endtask

  task automatic t_reset_in_stop();
    int f0 = 0, rp = 0;
    logic a, b;
    cpu_stop_n = 0; pci_stop_n = 0;
    repeat (200) tick();
    chk(cpu_t[0] == 1'b1 && pci_out[0] == 1'b0, "R4", "parked before reset",
        {cpu_t[0], pci_out[0]}, 2);
    do_reset();
    for (int k = 0; k < 40; k++) begin
      a = cpu_t[0]; b = pci_out[0]; tick();
      if (!cpu_t[0] && a) f0++;
      if (pci_out[0] && !b) rp++;
    end
    chk(f0 >= 1, "R1", "pair0 falls after reset under stop", f0, 1);
    chk(rp >= 1, "R1", "pci_out[0] rises after reset under stop", rp, 1);
    cpu_stop_n = 1; pci_stop_n = 1;
    repeat (200) tick();
  endtask

  initial begin
    t_reset();
    for (int it = 0; it < 4; it++) begin
      t_cpu_stop();
      t_cpu_release();
      t_pci_stop();
      t_pci_release();
    end
    t_reset_in_stop();
    chk(runts == 0, "R10", "short phases seen", runts, 0);
    chk(inv_err == 0, "R2", "complement mismatches", inv_err, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule